// File: doc/BRIEF.md
# Single-Vector Interrupt Sequencer

This block gathers fourteen interrupt requests from pins and on-chip peripherals into two 8-bit pending registers. A request can be taken only when a global enable bit and the request's own enable are both set. The block waits for the CPU to signal that the current instruction has finished before it takes a request. It then performs the whole entry of a single-vector interrupt without further help from the CPU: it clears the global enable, pushes the return address and the flags onto an internal-memory stack through its own stack pointer, reads a 16-bit branch target from the start of program memory and hands that target to the CPU. While this runs, the CPU holds its fetch.

The block also carries out the matching return. When the CPU requests it, the block pops the flags and the return address in the reverse order of the push and turns the global enable back on. There is no hardware priority and there is only one vector, so the service routine must find the cause by reading the pending registers. It clears each pending bit itself by writing a 0 to it.

Top module: `irq_seq_top`

## Requirements
- R1: Source index i (0..13) sets its pending bit on a request pulse. Indices 0-7 are bits 0-7 of pending register 1, which is read and written with reg_sel=0. Indices 8-13 are bits 0-5 of pending register 2, which uses reg_sel=1. Bits 6 and 7 of pending register 2 always read 0. Both registers read 0 after reset, and so do the mode register (reg_sel=2) and the stack pointer (reg_sel=3).
- R2: Writing a 0 to a pending bit clears it, and writing a 1 leaves it unchanged. Pending bits are never cleared by hardware.
- R3: A request pulse and a software clear of the same bit in the same cycle leave the bit set. A further pulse on a bit that is already set has no extra effect.
- R4: A request is taken only when the global enable (mode register bit 3) is 1, the source's src_en bit is 1 and instr_end is high.
- R5: In the cycle after a request is taken, the global enable reads 0.
- R6: Entry writes the PC low byte to SP-1, the PC high byte to SP-2 and FLAGS to SP-3, in that order. The stack pointer is decremented before each write and ends at SP-3.
- R7: The stack pointer wraps modulo 256, so an entry starting at SP=00h writes FFh, FEh and FDh.
- R8: Entry reads the target high byte from program address 0000h and then the low byte from 0001h. tgt_pc equals {high, low}.
- R9: int_active rises in the cycle a request is taken and stays high up to and including the single tgt_valid cycle, which is the sixth clock after acceptance. It is low in the cycle after tgt_valid.
- R10: A return pops FLAGS from SP, the PC high byte from SP+1 and the PC low byte from SP+2. ret_done comes four clocks after ret_req is taken. The stack pointer ends at SP+3, and the global enable reads 1 afterwards.
- R11: A pending, enabled request with the global enable set is not taken while instr_end stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 14 | Request pulses, one per source |
| src_en | input | 14 | Per-source enable bits |
| reg_sel | input | 2 | Register select: 0 pend1, 1 pend2, 2 mode, 3 stack pointer |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_sel) |
| instr_end | input | 1 | Instruction-boundary strobe from the CPU |
| ret_req | input | 1 | Return-from-interrupt request |
| cpu_pc | input | 16 | PC to save on entry |
| cpu_flags | input | 8 | FLAGS to save on entry |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | 8 | Stack address |
| stk_wdata | output | 8 | Stack write data |
| stk_rdata | input | 8 | Stack read data, same cycle |
| vec_re | output | 1 | Vector read strobe |
| vec_addr | output | 16 | Vector program address |
| vec_rdata | input | 8 | Vector read data, same cycle |
| int_active | output | 1 | Entry in progress; the CPU stalls its fetch |
| tgt_valid | output | 1 | Branch target valid (one cycle) |
| tgt_pc | output | 16 | Branch target |
| ret_done | output | 1 | Return finished (one cycle) |
| ret_pc | output | 16 | Restored PC |
| ret_flags | output | 8 | Restored FLAGS |

## Verification
The bench builds the block with its default parameters: fourteen sources, 8-bit registers and stack pointer, a 16-bit PC and the vector at address 0. This puts pending register 2, with its two dead top bits, and the wrap of the 8-bit stack pointer at 00h within reach of a few directed entries. With a width of 8, stack pointers near zero and near the top of the general-purpose area are both reachable, so the random entries place the stack at both ends. The bench also drives random request pulses against random byte-wide clears, so set-versus-clear collisions on shared pending bits occur often.

// File: rtl/irq_seq_pkg.sv
`timescale 1ns/1ps
package irq_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_L,
    ST_PUSH_H,
    ST_PUSH_F,
    ST_VEC_H,
    ST_VEC_L,
    ST_TGT,
    ST_POP_F,
    ST_POP_H,
    ST_POP_L,
    ST_RET
  } seq_state_e;

  localparam logic [1:0] SEL_PEND1 = 2'd0;
  localparam logic [1:0] SEL_PEND2 = 2'd1;
  localparam logic [1:0] SEL_MODE  = 2'd2;
  localparam logic [1:0] SEL_SP    = 2'd3;
  localparam int         GIE_BIT   = 3;

  // A set from hardware always wins over a clear from software
  function automatic logic pend_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
module irq_pend_bank
  import irq_seq_pkg::*;
#(
  parameter int NSRC = 14,
  parameter int RW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_set,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [RW-1:0]   wr_data,
  output logic [NSRC-1:0] pend
);

  logic [NSRC-1:0] clr_vec;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    localparam int          BANK = i / RW;
    localparam int          POS  = i % RW;
    localparam logic [1:0]  SEL  = 2'(BANK);

    assign clr_vec[i] = wr_en && (wr_sel == SEL) && !wr_data[POS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= pend_next(pend[i], src_set[i], clr_vec[i]);
    end
  end

endmodule

// File: rtl/irq_stack_ptr.sv
`timescale 1ns/1ps
module irq_stack_ptr #(
  parameter int SPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sw_we,
  input  logic [SPW-1:0] sw_data,
  input  logic           dec,
  input  logic           inc,
  output logic [SPW-1:0] sp
);

  function automatic logic [SPW-1:0] pre_push(input logic [SPW-1:0] v);
    return v - SPW'(1);
  endfunction

  function automatic logic [SPW-1:0] post_pop(input logic [SPW-1:0] v);
    return v + SPW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp <= '0;
    else if (dec)   sp <= pre_push(sp);
    else if (inc)   sp <= post_pop(sp);
    else if (sw_we) sp <= sw_data;
  end

endmodule

// File: rtl/irq_entry_fsm.sv
`timescale 1ns/1ps
module irq_entry_fsm
  import irq_seq_pkg::*;
#(
  parameter int              PCW      = 16,
  parameter int              DW       = 8,
  parameter int              SPW      = 8,
  parameter logic [PCW-1:0]  VEC_BASE = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           instr_end,
  input  logic           take,
  input  logic           ret_req,
  input  logic [PCW-1:0] cpu_pc,
  input  logic [DW-1:0]  cpu_flags,
  input  logic [SPW-1:0] sp,
  input  logic [DW-1:0]  stk_rdata,
  input  logic [DW-1:0]  vec_rdata,
  output logic           accept,
  output logic           stk_we,
  output logic           stk_re,
  output logic [SPW-1:0] stk_addr,
  output logic [DW-1:0]  stk_wdata,
  output logic           sp_dec,
  output logic           sp_inc,
  output logic           vec_re,
  output logic [PCW-1:0] vec_addr,
  output logic           int_active,
  output logic           tgt_valid,
  output logic [PCW-1:0] tgt_pc,
  output logic           ret_done,
  output logic [PCW-1:0] ret_pc,
  output logic [DW-1:0]  ret_flags,
  output logic           gie_clr,
  output logic           gie_set
);

  localparam int HB = PCW / 2;

  seq_state_e     state_q, state_d;
  logic [PCW-1:0] pc_lat;
  logic [DW-1:0]  fl_lat;
  logic [PCW-1:0] tgt_q;
  logic [PCW-1:0] rpc_q;
  logic [DW-1:0]  rfl_q;
  logic           in_entry;

  function automatic logic [SPW-1:0] below(input logic [SPW-1:0] v);
    return v - SPW'(1);
  endfunction

  assign accept   = (state_q == ST_IDLE) && instr_end && take;
  assign in_entry = (state_q == ST_PUSH_L) || (state_q == ST_PUSH_H) ||
                    (state_q == ST_PUSH_F) || (state_q == ST_VEC_H)  ||
                    (state_q == ST_VEC_L)  || (state_q == ST_TGT);

  always_comb begin
    state_d   = state_q;
    stk_we    = 1'b0;
    stk_re    = 1'b0;
    stk_addr  = sp;
    stk_wdata = '0;
    sp_dec    = 1'b0;
    sp_inc    = 1'b0;
    vec_re    = 1'b0;
    vec_addr  = VEC_BASE;
    gie_set   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept)       state_d = ST_PUSH_L;
        else if (ret_req) state_d = ST_POP_F;
      end
      ST_PUSH_L: begin
        stk_we = 1'b1; stk_addr = below(sp); stk_wdata = pc_lat[HB-1:0];
        sp_dec = 1'b1; state_d = ST_PUSH_H;
      end
      ST_PUSH_H: begin
        stk_we = 1'b1; stk_addr = below(sp); stk_wdata = pc_lat[PCW-1:HB];
        sp_dec = 1'b1; state_d = ST_PUSH_F;
      end
      ST_PUSH_F: begin
        stk_we = 1'b1; stk_addr = below(sp); stk_wdata = fl_lat;
        sp_dec = 1'b1; state_d = ST_VEC_H;
      end
      ST_VEC_H: begin
        vec_re = 1'b1; vec_addr = VEC_BASE; state_d = ST_VEC_L;
      end
      ST_VEC_L: begin
        vec_re = 1'b1; vec_addr = VEC_BASE + PCW'(1); state_d = ST_TGT;
      end
      ST_TGT:   state_d = ST_IDLE;
      ST_POP_F: begin stk_re = 1'b1; sp_inc = 1'b1; state_d = ST_POP_H; end
      ST_POP_H: begin stk_re = 1'b1; sp_inc = 1'b1; state_d = ST_POP_L; end
      ST_POP_L: begin stk_re = 1'b1; sp_inc = 1'b1; state_d = ST_RET;   end
      ST_RET: begin gie_set = 1'b1; state_d = ST_IDLE; end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_lat  <= '0;
      fl_lat  <= '0;
      tgt_q   <= '0;
      rpc_q   <= '0;
      rfl_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        pc_lat <= cpu_pc;
        fl_lat <= cpu_flags;
      end
      case (state_q)
        ST_VEC_H: tgt_q[PCW-1:HB] <= vec_rdata;
        ST_VEC_L: tgt_q[HB-1:0]   <= vec_rdata;
        ST_POP_F: rfl_q           <= stk_rdata;
        ST_POP_H: rpc_q[PCW-1:HB] <= stk_rdata;
        ST_POP_L: rpc_q[HB-1:0]   <= stk_rdata;
        default: ;
      endcase
    end
  end

  assign gie_clr    = accept;
  assign int_active = accept || in_entry;
  assign tgt_valid  = (state_q == ST_TGT);
  assign tgt_pc     = tgt_q;
  assign ret_done   = (state_q == ST_RET);
  assign ret_pc     = rpc_q;
  assign ret_flags  = rfl_q;

endmodule

// File: rtl/irq_seq_top.sv
`timescale 1ns/1ps
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter int              NSRC     = 14,
  parameter int              RW       = 8,
  parameter int              SPW      = 8,
  parameter int              PCW      = 16,
  parameter logic [PCW-1:0]  VEC_BASE = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-1:0] src_en,
  input  logic [1:0]      reg_sel,
  input  logic            reg_we,
  input  logic [RW-1:0]   reg_wdata,
  output logic [RW-1:0]   reg_rdata,
  input  logic            instr_end,
  input  logic            ret_req,
  input  logic [PCW-1:0]  cpu_pc,
  input  logic [RW-1:0]   cpu_flags,
  output logic            stk_we,
  output logic            stk_re,
  output logic [SPW-1:0]  stk_addr,
  output logic [RW-1:0]   stk_wdata,
  input  logic [RW-1:0]   stk_rdata,
  output logic            vec_re,
  output logic [PCW-1:0]  vec_addr,
  input  logic [RW-1:0]   vec_rdata,
  output logic            int_active,
  output logic            tgt_valid,
  output logic [PCW-1:0]  tgt_pc,
  output logic            ret_done,
  output logic [PCW-1:0]  ret_pc,
  output logic [RW-1:0]   ret_flags
);

  localparam int PADW = 2 * RW;

  logic [NSRC-1:0] pend_q;
  logic [PADW-1:0] pend_pad;
  logic [SPW-1:0]  sp_q;
  logic            gie_q;
  logic            take;
  logic            accept_evt;
  logic            sp_dec, sp_inc;
  logic            gie_clr, gie_set;
  logic            mode_we, sp_we;

  assign mode_we  = reg_we && (reg_sel == SEL_MODE);
  assign sp_we    = reg_we && (reg_sel == SEL_SP);
  assign pend_pad = {{(PADW-NSRC){1'b0}}, pend_q};
  assign take     = gie_q && |(pend_q & src_en);

  irq_pend_bank #(.NSRC(NSRC), .RW(RW)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_set(src_req),
    .wr_en(reg_we), .wr_sel(reg_sel), .wr_data(reg_wdata), .pend(pend_q)
  );

  irq_stack_ptr #(.SPW(SPW)) u_sp (
    .clk(clk), .rst_n(rst_n), .sw_we(sp_we), .sw_data(reg_wdata[SPW-1:0]),
    .dec(sp_dec), .inc(sp_inc), .sp(sp_q)
  );

  irq_entry_fsm #(.PCW(PCW), .DW(RW), .SPW(SPW), .VEC_BASE(VEC_BASE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .instr_end(instr_end), .take(take),
    .ret_req(ret_req), .cpu_pc(cpu_pc), .cpu_flags(cpu_flags), .sp(sp_q),
    .stk_rdata(stk_rdata), .vec_rdata(vec_rdata), .accept(accept_evt),
    .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .sp_dec(sp_dec), .sp_inc(sp_inc),
    .vec_re(vec_re), .vec_addr(vec_addr), .int_active(int_active),
    .tgt_valid(tgt_valid), .tgt_pc(tgt_pc), .ret_done(ret_done),
    .ret_pc(ret_pc), .ret_flags(ret_flags), .gie_clr(gie_clr),
    .gie_set(gie_set)
  );

  // Global enable: entry clear beats return set beats software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gie_q <= 1'b0;
    else if (gie_clr) gie_q <= 1'b0;
    else if (gie_set) gie_q <= 1'b1;
    else if (mode_we) gie_q <= reg_wdata[GIE_BIT];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_PEND1: reg_rdata = pend_pad[RW-1:0];
      SEL_PEND2: reg_rdata = pend_pad[PADW-1:RW];
      SEL_MODE:  reg_rdata[GIE_BIT] = gie_q;
      SEL_SP:    reg_rdata = RW'(sp_q);
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_seq_chk.sv
`timescale 1ns/1ps
module irq_seq_chk #(
  parameter int NSRC = 14,
  parameter int PCW  = 16,
  parameter int SPW  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            instr_end,
  input logic            gie,
  input logic            reg_we,
  input logic            int_active,
  input logic            tgt_valid,
  input logic            stk_we,
  input logic [SPW-1:0]  stk_addr,
  input logic [SPW-1:0]  sp,
  input logic            vec_re,
  input logic [PCW-1:0]  vec_addr,
  input logic [NSRC-1:0] src_req,
  input logic [NSRC-1:0] pend,
  input logic            ret_done
);

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_req) |=> ((pend & $past(src_req)) == $past(src_req)));

  p_no_hw_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ((pend & $past(pend)) == $past(pend)));

  p_accept_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (gie && instr_end));

  p_gie_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !gie);

  p_push_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |=> (sp == $past(stk_addr)));

  p_vec_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_re |-> (vec_addr[PCW-1:1] == '0));

  p_active_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_active) |-> accept);

  p_active_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |=> !int_active);

  p_ret_gie_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |=> gie);

endmodule

bind irq_seq_top irq_seq_chk #(.NSRC(NSRC), .PCW(PCW), .SPW(SPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept_evt), .instr_end(instr_end),
  .gie(gie_q), .reg_we(reg_we), .int_active(int_active),
  .tgt_valid(tgt_valid), .stk_we(stk_we), .stk_addr(stk_addr), .sp(sp_q),
  .vec_re(vec_re), .vec_addr(vec_addr), .src_req(src_req), .pend(pend_q),
  .ret_done(ret_done)
);

// File: tb/irq_seq_bench.sv
`timescale 1ns/1ps
module irq_seq_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] src_req = '0;
  logic [13:0] src_en = '0;
  logic [1:0]  reg_sel = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        instr_end = 1'b0;
  logic        ret_req = 1'b0;
  logic [15:0] cpu_pc = '0;
  logic [7:0]  cpu_flags = '0;
  logic        stk_we, stk_re, vec_re;
  logic [7:0]  stk_addr, stk_wdata, stk_rdata, vec_rdata;
  logic [15:0] vec_addr, tgt_pc, ret_pc;
  logic        int_active, tgt_valid, ret_done;
  logic [7:0]  ret_flags;
  logic [7:0]  smem [256];
  logic [7:0]  vhi = 8'h00, vlo = 8'h00;
  int          tests = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (stk_we) smem[stk_addr] <= stk_wdata;
  assign stk_rdata = smem[stk_addr];
  assign vec_rdata = (vec_addr == 16'h0000) ? vhi : (vec_addr == 16'h0001) ? vlo : 8'h00;

  irq_seq_top u_irq_seq_top (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] v);
    reg_sel = sel; #0.5; v = reg_rdata;
  endtask

  function automatic logic [7:0] sp_sub(input logic [7:0] s, input int n);
    return s - 8'(n);
  endfunction

  task automatic do_entry(input logic [15:0] pc, input logic [7:0] fl,
                          input logic [7:0] vh, input logic [7:0] vl, input logic [7:0] sp0);
    logic [7:0] v;
    wr(2'd3, sp0);
    vhi = vh; vlo = vl;
    @(negedge clk); cpu_pc = pc; cpu_flags = fl; instr_end = 1'b1;
    @(negedge clk); instr_end = 1'b0;
    chk(int_active == 1'b1, "R9 active after accept", 32'(int_active), 32'd1);
    rd(2'd2, v);
    chk(v[3] == 1'b0, "R5 gie cleared", 32'(v), 32'h0);
    repeat (4) @(negedge clk);
    chk(tgt_valid == 1'b0, "R9 target not early", 32'(tgt_valid), 32'd0);
    @(negedge clk);
    chk(tgt_valid && int_active, "R9 target cycle", {tgt_valid, int_active}, 32'h3);
    chk(tgt_pc == {vh, vl}, "R8 target value", 32'(tgt_pc), {16'h0, vh, vl});
    @(negedge clk);
    chk(int_active == 1'b0, "R9 active drops", 32'(int_active), 32'd0);
    chk(smem[sp_sub(sp0,1)] == pc[7:0],  "R6 pcl at sp-1", 32'(smem[sp_sub(sp0,1)]), 32'(pc[7:0]));
    chk(smem[sp_sub(sp0,2)] == pc[15:8], "R6 pch at sp-2", 32'(smem[sp_sub(sp0,2)]), 32'(pc[15:8]));
    chk(smem[sp_sub(sp0,3)] == fl,       "R6 flags at sp-3", 32'(smem[sp_sub(sp0,3)]), 32'(fl));
    rd(2'd3, v);
    chk(v == sp_sub(sp0,3), "R6 R7 final sp", 32'(v), 32'(sp_sub(sp0,3)));
  endtask

  task automatic do_ret(input logic [15:0] pc, input logic [7:0] fl, input logic [7:0] sp0);
    logic [7:0] v;
    @(negedge clk); ret_req = 1'b1;
    @(negedge clk); ret_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(ret_done == 1'b0, "R10 not early", 32'(ret_done), 32'd0);
    @(negedge clk);
    chk(ret_done == 1'b1, "R10 done", 32'(ret_done), 32'd1);
    chk(ret_pc == pc, "R10 pc", 32'(ret_pc), 32'(pc));
    chk(ret_flags == fl, "R10 flags", 32'(ret_flags), 32'(fl));
    @(negedge clk);
    rd(2'd2, v);
    chk(v == 8'h08, "R10 gie back", 32'(v), 32'h08);
    rd(2'd3, v);
    chk(v == sp0, "R10 sp restored", 32'(v), 32'(sp0));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [15:0] exp_p;
    logic [15:0] pc;
    logic [7:0]  fl;
    logic [7:0]  sp0;
    void'($urandom(32'h1A2B3C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk(v == 8'h00, "R1 reset pend1", 32'(v), 0);
    rd(2'd1, v); chk(v == 8'h00, "R1 reset pend2", 32'(v), 0);
    rd(2'd2, v); chk(v == 8'h00, "R1 reset mode", 32'(v), 0);
    rd(2'd3, v); chk(v == 8'h00, "R1 reset sp", 32'(v), 0);

    // R1: all sources, pend2 top bits dead
    @(negedge clk); src_req = 14'h3FFF;
    @(negedge clk); src_req = '0;
    rd(2'd0, v); chk(v == 8'hFF, "R1 all pend1", 32'(v), 32'hFF);
    rd(2'd1, v); chk(v == 8'h3F, "R1 pend2 bits 7:6 zero", 32'(v), 32'h3F);
    // R2: write ones keeps, zero clears one bit
    wr(2'd0, 8'hFD);
    rd(2'd0, v); chk(v == 8'hFD, "R2 clear single bit", 32'(v), 32'hFD);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    rd(2'd0, v); chk(v == 8'h00, "R2 clear pend1", 32'(v), 0);
    rd(2'd1, v); chk(v == 8'h00, "R2 clear pend2", 32'(v), 0);
    // R3: set beats clear in same cycle
    @(negedge clk); src_req = 14'h0008; reg_sel = 2'd0; reg_we = 1'b1; reg_wdata = 8'h00;
    @(negedge clk); src_req = '0; reg_we = 1'b0;
    rd(2'd0, v); chk(v == 8'h08, "R3 set wins", 32'(v), 32'h08);
    @(negedge clk); src_req = 14'h0008;
    @(negedge clk); src_req = '0;
    wr(2'd0, 8'hF7);
    rd(2'd0, v); chk(v == 8'h00, "R3 repeat pulse no effect", 32'(v), 0);

    // R11: no boundary, no entry
    src_en = 14'h3FFF;
    wr(2'd2, 8'h08);
    @(negedge clk); src_req = 14'h0100;
    @(negedge clk); src_req = '0;
    rd(2'd1, v); chk(v == 8'h01, "R1 timer source bit 8", 32'(v), 32'h01);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(int_active == 1'b0, "R11 no boundary", 32'(int_active), 0);
    end
    // R4: gie off
    wr(2'd2, 8'h00);
    @(negedge clk); instr_end = 1'b1; #0.5;
    chk(int_active == 1'b0, "R4 gie off", 32'(int_active), 0);
    @(negedge clk); instr_end = 1'b0;
    chk(int_active == 1'b0, "R4 gie off next", 32'(int_active), 0);
    // R4: source disabled
    wr(2'd2, 8'h08);
    src_en = 14'h3EFF;
    @(negedge clk); instr_end = 1'b1; #0.5;
    chk(int_active == 1'b0, "R4 src disabled", 32'(int_active), 0);
    @(negedge clk); instr_end = 1'b0;
    chk(int_active == 1'b0, "R4 src disabled next", 32'(int_active), 0);
    src_en = 14'h3FFF;

    pc = 16'h1234; fl = 8'hA0; sp0 = 8'hB8;
    do_entry(pc, fl, 8'h05, 8'h40, sp0);
    do_ret(pc, fl, sp0);
    // R7 wrap
    pc = 16'hBEEF; fl = 8'h50; sp0 = 8'h00;
    do_entry(pc, fl, 8'h07, 8'h11, sp0);
    do_ret(pc, fl, sp0);
    wr(2'd1, 8'h00);

    // random entries from a single random source
    for (int n = 0; n < 6; n++) begin
      int idx;
      idx = int'($urandom % 14);
      src_en = 14'(1 << idx);
      @(negedge clk); src_req = 14'(1 << idx);
      @(negedge clk); src_req = '0;
      pc  = 16'($urandom);
      fl  = 8'($urandom) & 8'hF0;
      sp0 = (n % 2 == 0) ? 8'($urandom % 4) : 8'(8'hB4 + $urandom % 4);
      do_entry(pc, fl, 8'($urandom), 8'($urandom), sp0);
      do_ret(pc, fl, sp0);
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    end

    // random pending traffic against byte-wide clears, no boundary
    wr(2'd2, 8'h00);
    exp_p = '0;
    for (int n = 0; n < 300; n++) begin
      logic [13:0] s;
      logic [15:0] clr;
      logic [1:0]  sel;
      logic [7:0]  d;
      bit          w;
      s   = 14'($urandom & $urandom);
      w   = $urandom % 2;
      sel = 2'($urandom % 2);
      d   = 8'($urandom | $urandom);
      clr = '0;
      if (w) clr = (sel == 2'd0) ? {8'h00, ~d} : {~d, 8'h00};
      @(negedge clk); src_req = s; reg_sel = sel; reg_we = w; reg_wdata = d;
      @(negedge clk); src_req = '0; reg_we = 1'b0;
      exp_p = ((exp_p & ~clr) | {2'b00, s}) & 16'h3FFF;
      rd(2'd0, v);
      chk(v == exp_p[7:0], "R2 R3 random pend1", 32'(v), 32'(exp_p[7:0]));
      rd(2'd1, v);
      chk(v == exp_p[15:8], "R1 R2 random pend2", 32'(v), 32'(exp_p[15:8]));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule